// File: doc/BRIEF.md
# Character LCD Nibble Write Engine

This block accepts one byte at a time from a host through a valid/ready handshake. It writes that byte to a character LCD controller over a four-wire data path, so each byte goes out as two enable strobes: the upper nibble first, then the lower nibble. Register-select comes with the request, and read/write is always driven low. The block works out the setup, strobe width, recovery and enable-cycle spacing from the clock frequency parameter, taking the smallest whole number of cycles that meets each nanosecond minimum.

After the last strobe the block waits for the controller's execution time, then raises ready again. It decodes the byte to pick the length of this wait. The clear command and the cursor-home commands get the long wait, and every other instruction or data byte gets the short one. An initialization sequencer can set the single-nibble flag, so that only the upper nibble of the byte is sent, as one strobe.

Top module: `lcd_nib_engine`

## Requirements
- R1: A full request produces exactly two rising edges of `lcd_e`. `lcd_db` carries `req_byte[7:4]` during the first strobe and `req_byte[3:0]` during the second. `lcd_db[3]` maps to the bus's most significant data line.
- R2: `lcd_rs` equals the request's `req_rs` during every strobe of that transfer (0 = instruction, 1 = data), and `lcd_rw` is 0 at all times.
- R3: Before each rising edge of `lcd_e`, `lcd_rs` and `lcd_db` hold their strobe values with `lcd_e` low for at least AS = ceil(T_AS_NS·CLK_HZ/1e9) cycles.
- R4: `lcd_e` stays high for exactly PW = max(ceil(T_PW_NS), ceil(T_DSW_NS)) cycles. The two rising edges of one byte are at least ceil(T_CYC_NS) cycles apart.
- R5: `lcd_rs` and `lcd_db` do not change while `lcd_e` is high, nor in the first cycle after `lcd_e` falls.
- R6: With `req_rs`=0, byte values 0x01, 0x02 and 0x03 select the long execution wait ceil(EXEC_LONG_NS). Every other byte, and any byte with `req_rs`=1, selects the short wait ceil(EXEC_SHORT_NS).
- R7: `req_ready` falls in the cycle after an accepted request (`req_valid` and `req_ready` both high at a clock edge). It stays low for exactly N·(AS+PW+REC)+EXEC cycles, where N is the number of strobes and REC = max(ceil(T_AH_NS), ceil(T_CYC_NS)−AS−PW).
- R8: While `arst_n` is low, `req_ready`=1, `lcd_e`=0, `lcd_rs`=0 and `lcd_db`=0, and a transfer in progress is dropped at once. No further strobe follows the release.
- R9: A request presented while `req_ready` is 0 is ignored. It produces no strobe, neither during nor after the current transfer.
- R10: With `req_nibble_only`=1, exactly one strobe carries `req_byte[7:4]`. N is 1 in R7, and the wait still follows R6 for the full byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| arst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a byte |
| req_rs | input | 1 | Register select for the byte (0 instruction, 1 data) |
| req_nibble_only | input | 1 | Send only the upper nibble, as one strobe |
| req_byte | input | 8 | Byte to write |
| req_ready | output | 1 | Engine idle, can accept a request |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write to the display, always write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 4 | Upper four data lines of the display |

## Verification
A table of requests mixes instructions and data whose two nibbles differ. This catches nibbles sent in the wrong order or on the wrong register-select level. The table also covers the three long-wait codes, their neighbours 0x00, 0x04 and 0x07, and 0x01 sent as data, so an over-wide or under-wide command decode shows up as a wrong ready-low count. Single-nibble entries, including one carrying the clear code, separate the strobe count from the wait selection. Directed cases present a request while busy and assert reset in the middle of a strobe.

// File: rtl/lcd_nib_pkg.sv
package lcd_nib_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_RECOV  = 3'd3,
    PH_EXEC   = 3'd4
  } lcd_phase_e;

  // Smallest cycle count at clk_hz that covers ns nanoseconds.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                               longint unsigned ns);
    longint unsigned prod;
    prod = clk_hz * ns;
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_nib_rst_sync.sv
module lcd_nib_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/lcd_nib_timer.sv
module lcd_nib_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_nib_exec_sel.sv
module lcd_nib_exec_sel (
  input  logic       rs,
  input  logic [7:0] byte_in,
  output logic       long_wait
);
  // Instruction codes 0x01..0x03 (clear, return home) need the long wait.
  always_comb begin
    long_wait = !rs && (byte_in[7:2] == 6'd0) && (byte_in[1:0] != 2'd0);
  end
endmodule

// File: rtl/lcd_nib_engine.sv
module lcd_nib_engine
  import lcd_nib_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned T_AS_NS       = 140,
  parameter int unsigned T_PW_NS       = 450,
  parameter int unsigned T_DSW_NS      = 195,
  parameter int unsigned T_AH_NS       = 10,
  parameter int unsigned T_CYC_NS      = 1000,
  parameter int unsigned EXEC_SHORT_NS = 40_000,
  parameter int unsigned EXEC_LONG_NS  = 1_640_000
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       req_valid,
  input  logic       req_rs,
  input  logic       req_nibble_only,
  input  logic [7:0] req_byte,
  output logic       req_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_db
);

  localparam int unsigned AS_CYC  = max_u(1, ns_to_cycles(CLK_HZ, T_AS_NS));
  localparam int unsigned PW_CYC  = max_u(1, max_u(ns_to_cycles(CLK_HZ, T_PW_NS),
                                                   ns_to_cycles(CLK_HZ, T_DSW_NS)));
  localparam int unsigned AH_CYC  = max_u(1, ns_to_cycles(CLK_HZ, T_AH_NS));
  localparam int unsigned CY_CYC  = ns_to_cycles(CLK_HZ, T_CYC_NS);
  localparam int unsigned REC_CYC = (CY_CYC > AS_CYC + PW_CYC + AH_CYC) ?
                                    (CY_CYC - AS_CYC - PW_CYC) : AH_CYC;
  localparam int unsigned XS_CYC  = max_u(1, ns_to_cycles(CLK_HZ, EXEC_SHORT_NS));
  localparam int unsigned XL_CYC  = max_u(1, ns_to_cycles(CLK_HZ, EXEC_LONG_NS));
  localparam int unsigned CNT_MAX = max_u(max_u(max_u(AS_CYC, PW_CYC), REC_CYC),
                                          max_u(XS_CYC, XL_CYC));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] LD_AS  = CNT_W'(AS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PW  = CNT_W'(PW_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_XS  = CNT_W'(XS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_XL  = CNT_W'(XL_CYC - 1);

  logic srst_n;

  lcd_nib_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  lcd_phase_e       phase_q, phase_d;
  logic             rs_q, rs_d;
  logic [3:0]       db_q, db_d;
  logic [3:0]       lo_q, lo_d;
  logic             second_q, second_d;
  logic             long_q, long_d;
  logic             e_q, e_d;
  logic             rdy_q, rdy_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             req_long;
  logic             accept;

  lcd_nib_exec_sel u_sel (
    .rs        (req_rs),
    .byte_in   (req_byte),
    .long_wait (req_long)
  );

  lcd_nib_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign accept = req_valid && rdy_q;

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    rs_d     = rs_q;
    db_d     = db_q;
    lo_d     = lo_q;
    second_d = second_q;
    long_d   = long_q;
    e_d      = e_q;
    rdy_d    = rdy_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          rs_d     = req_rs;
          db_d     = req_byte[7:4];
          lo_d     = req_byte[3:0];
          second_d = !req_nibble_only;
          long_d   = req_long;
          rdy_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = LD_AS;
          phase_d  = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (tmr_done) begin
          e_d      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_PW;
          phase_d  = PH_STROBE;
        end
      end
      PH_STROBE: begin
        if (tmr_done) begin
          e_d      = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = LD_REC;
          phase_d  = PH_RECOV;
        end
      end
      PH_RECOV: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (second_q) begin
            second_d = 1'b0;
            db_d     = lo_q;
            tmr_val  = LD_AS;
            phase_d  = PH_SETUP;
          end else begin
            tmr_val  = long_q ? LD_XL : LD_XS;
            phase_d  = PH_EXEC;
          end
        end
      end
      PH_EXEC: begin
        if (tmr_done) begin
          rdy_d   = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: begin
        rdy_d   = 1'b1;
        e_d     = 1'b0;
        phase_d = PH_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q  <= PH_IDLE;
      rs_q     <= 1'b0;
      db_q     <= 4'd0;
      lo_q     <= 4'd0;
      second_q <= 1'b0;
      long_q   <= 1'b0;
      e_q      <= 1'b0;
      rdy_q    <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      rs_q     <= rs_d;
      db_q     <= db_d;
      lo_q     <= lo_d;
      second_q <= second_d;
      long_q   <= long_d;
      e_q      <= e_d;
      rdy_q    <= rdy_d;
    end
  end

  assign req_ready = rdy_q;
  assign lcd_rs    = rs_q;
  assign lcd_rw    = 1'b0;
  assign lcd_e     = e_q;
  assign lcd_db    = db_q;

  // R8
  idle_e_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    req_ready |-> !lcd_e);

  // R5
  high_bus_stable_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (lcd_e && $past(lcd_e)) |-> $stable({lcd_rs, lcd_db}));

  // R5
  fall_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(lcd_e) |-> $stable({lcd_rs, lcd_db}));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(req_ready) |-> ($past(phase_q) == PH_EXEC));

endmodule

// File: tb/lcd_nib_engine_test.sv
`timescale 1ns/1ps
module lcd_nib_engine_test;

  localparam int CLK_HZ   = 50_000_000;
  localparam int SHORT_NS = 4000;
  localparam int LONG_NS  = 164000;

  function automatic int cyc(longint ns);
    return int'((ns * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  localparam int AS  = cyc(140);
  localparam int PW  = (cyc(450) > cyc(195)) ? cyc(450) : cyc(195);
  localparam int CYE = cyc(1000);
  localparam int REC = (CYE - AS - PW > cyc(10)) ? (CYE - AS - PW) : cyc(10);
  localparam int EXS = cyc(SHORT_NS);
  localparam int EXL = cyc(LONG_NS);

  // {long_expected, nibble_only, rs, byte}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    11'h028, 11'h141, 11'h401, 11'h402, 11'h403, 11'h000, 11'h004,
    11'h101, 11'h230, 11'h220, 11'h1A5, 11'h080, 11'h601, 11'h007
  };

  logic       clk;
  logic       arst_n;
  logic       req_valid;
  logic       req_rs;
  logic       req_nibble_only;
  logic [7:0] req_byte;
  logic       req_ready;
  logic       lcd_rs;
  logic       lcd_rw;
  logic       lcd_e;
  logic [3:0] lcd_db;

  lcd_nib_engine #(
    .CLK_HZ(CLK_HZ), .EXEC_SHORT_NS(SHORT_NS), .EXEC_LONG_NS(LONG_NS)
  ) uut (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_rs(req_rs),
    .req_nibble_only(req_nibble_only), .req_byte(req_byte),
    .req_ready(req_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .lcd_db(lcd_db)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Bus monitor, sampling on the falling clock edge
  int         cyc_n = 0;
  int         rises = 0;
  int         busy_n = 0;
  int         rw_bad = 0;
  int         stable_n = 0;
  logic       e_prev = 1'b0;
  logic [4:0] prev_bus = 5'd0;
  logic [4:0] rise_bus [64];
  int         rise_at  [64];
  int         width_of [64];
  int         setup_of [64];
  logic       hold_ok  [64];
  logic       hi_ok    [64];

  always @(negedge clk) begin
    logic [4:0] bus;
    int idx;
    bus = {lcd_rs, lcd_db};
    cyc_n++;
    if (lcd_rw) rw_bad++;
    if (!req_ready) busy_n++;
    if (lcd_e && !e_prev) begin
      idx = rises & 63;
      rise_bus[idx] = bus;
      rise_at[idx]  = cyc_n;
      setup_of[idx] = (bus == prev_bus) ? stable_n : 0;
      width_of[idx] = 0;
      hi_ok[idx]    = 1'b1;
      hold_ok[idx]  = 1'b0;
      rises++;
    end
    if (lcd_e) begin
      idx = (rises - 1) & 63;
      width_of[idx]++;
      if (bus != rise_bus[idx]) hi_ok[idx] = 1'b0;
      stable_n = 0;
    end else begin
      if (e_prev) hold_ok[(rises - 1) & 63] = (bus == prev_bus);
      stable_n = (bus == prev_bus) ? stable_n + 1 : 1;
    end
    prev_bus = bus;
    e_prev   = lcd_e;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic offer(input logic rs, input logic [7:0] b, input logic nib);
    @(posedge clk); #1;
    req_rs = rs; req_byte = b; req_nibble_only = nib; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!req_ready) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic run_vec(input logic [10:0] v);
    int r0, b0, n, exp_busy, idx;
    logic [4:0] exp_bus;
    r0 = rises; b0 = busy_n;
    offer(v[8], v[7:0], v[9]);
    wait_ready();
    n = v[9] ? 1 : 2;
    exp_busy = n * (AS + PW + REC) + (v[10] ? EXL : EXS);
    chk(rises - r0 == n, v[9] ? "R10 strobe count" : "R1 strobe count", rises - r0, n);
    for (int j = 0; j < n && j < rises - r0; j++) begin
      idx = (r0 + j) & 63;
      exp_bus = {v[8], (j == 0) ? v[7:4] : v[3:0]};
      chk(rise_bus[idx][3:0] == exp_bus[3:0], "R1 nibble", rise_bus[idx][3:0], exp_bus[3:0]);
      chk(rise_bus[idx][4] == exp_bus[4], "R2 rs level", rise_bus[idx][4], exp_bus[4]);
      chk(setup_of[idx] >= AS, "R3 setup", setup_of[idx], AS);
      chk(width_of[idx] == PW, "R4 pulse width", width_of[idx], PW);
      chk(hi_ok[idx] && hold_ok[idx], "R5 bus stable/hold", hi_ok[idx] && hold_ok[idx], 1);
      if (j == 1)
        chk(rise_at[idx] - rise_at[(r0) & 63] >= CYE, "R4 enable cycle",
            rise_at[idx] - rise_at[r0 & 63], CYE);
    end
    chk(busy_n - b0 == exp_busy, v[10] ? "R6 long wait / R7 busy" : "R6 short wait / R7 busy",
        busy_n - b0, exp_busy);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=190000 cycles expected=run complete");
    summary();
    $finish;
  end

  initial begin
    int r0;
    arst_n = 1'b0; req_valid = 1'b0; req_rs = 1'b0;
    req_byte = 8'd0; req_nibble_only = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R8 reset state
    chk(req_ready == 1'b1, "R8 ready in reset", req_ready, 1);
    chk({lcd_e, lcd_rs, lcd_db} == 6'd0, "R8 bus in reset", {lcd_e, lcd_rs, lcd_db}, 0);
    arst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R8 ready after release", req_ready, 1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: request during busy is ignored
    r0 = rises;
    offer(1'b0, 8'h28, 1'b0);
    repeat (40) @(posedge clk);
    #1;
    req_rs = 1'b1; req_byte = 8'hFF; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_ready();
    repeat (300) @(posedge clk);
    #1;
    chk(rises - r0 == 2, "R9 busy request ignored", rises - r0, 2);
    chk(rise_bus[(r0 + 1) & 63] == 5'h08, "R9 second nibble untouched",
        rise_bus[(r0 + 1) & 63], 5'h08);

    // R8: reset in the middle of a strobe
    offer(1'b1, 8'h5A, 1'b0);
    repeat (AS + 5) @(posedge clk);
    #1;
    chk(lcd_e == 1'b1, "R4 strobe active before abort", lcd_e, 1);
    arst_n = 1'b0;
    #1;
    chk(lcd_e == 1'b0 && req_ready == 1'b1, "R8 abort immediate",
        {lcd_e, req_ready}, 2'b01);
    repeat (3) @(posedge clk);
    #1;
    arst_n = 1'b1;
    r0 = rises;
    repeat (EXS + 300) @(posedge clk);
    #1;
    chk(rises == r0, "R8 no strobe after abort", rises - r0, 0);
    run_vec(11'h141);

    chk(rw_bad == 0, "R2 rw low", rw_bad, 0);
    summary();
    $finish;
  end

endmodule